// File: doc/BRIEF.md
# Tiled Registered AND-Chain Bus

This block links one master in a fixed base area to a row of identical tile slots. Every tile slot holds the same bus segment. Each segment registers all of its inputs and outputs, and it adds one AND stage to a shared return line that runs through the whole row. A tile that does not drive presents all ones, so the line carries the AND of the active drivers. The master's command wires (strobe, write flag, address, write data) fan out to every segment. Each segment captures them, so any tile sees a master transfer exactly two clock edges after the master presents it, wherever the tile sits in the row.

Per-tile control travels on the same common wires, so no tile differs from another. Toward the tiles, the master places a binary tile number and a small control field on shared wires. Each segment compares that number with its own stored tile number and passes the field only on a match. Toward the master, each tile clears only its own group of bits on a one-hot return line, at the position given by its stored number. Bit 0 of each tile's group is an address acknowledge and bit 1 is a data acknowledge. The master port folds these into two flags.

The stored tile numbers are written only by a one-cycle initialisation pulse that travels down an increment chain, so the segment at position i takes number i. After that they are held whatever the tile logic does. A per-tile I/O enable takes a tile off the data line and freezes its data input registers. Commands can be issued on consecutive cycles, one word per cycle.

Top module: `tbus_top`

## Requirements
- R1: While reset is asserted, and right after it is released: m_rdata is all ones; m_send, m_aack and m_dack are zero; and every tile-side output (t_stb, t_we, t_addr, t_wdata, t_rbus, t_recv) is zero. No tile holds a valid tile number after reset.
- R2: A value of m_stb presented before clock edge k appears on t_stb of every tile whose t_ioen is high at edge k+1, and it is visible after edge k+1. Tiles with t_ioen low show t_stb = 0.
- R3: m_rdata, after edge k+1, equals the bitwise AND of t_dout over all tiles that had both t_drv and t_ioen high at edge k. It is all ones when no tile qualifies.
- R4: t_rbus of a tile with t_ioen high takes the same AND value as m_rdata, with the same two-edge latency. This is the tile-to-tile path.
- R5: While a tile's t_ioen is low, its t_dout has no effect on m_rdata or on t_rbus of any tile, even with t_drv high. Its t_we, t_addr, t_wdata and t_rbus keep their last values.
- R6: A one-cycle m_init pulse gives the segment at position i (position 0 nearest the master) tile number i, valid after the second edge. Tile numbers and their valid flags change at no other time.
- R7: t_recv of a tile with a valid tile number equal to m_tsel takes m_ded two edges later. Every other tile reads zero. All tiles read zero before the first m_init.
- R8: Bit a*DED_W+k of m_send is 1 exactly when the tile holding number a had t_send bit k high two edges earlier. m_send is zero before the first m_init.
- R9: m_aack is the OR over all numbered tiles of t_send bit 0, and m_dack is the OR of t_send bit 1, both with the same two-edge latency.
- R10: Commands presented on consecutive cycles reach the tiles in order, one per cycle. t_addr, t_wdata and t_we show the values of the most recent command with m_stb high; those registers load only when m_stb is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| m_stb | input | 1 | Master command strobe |
| m_we | input | 1 | Master write flag |
| m_addr | input | ADDR_W | Master address |
| m_wdata | input | DATA_W | Master write data |
| m_tsel | input | TID_W | Binary tile number for per-tile control |
| m_ded | input | DED_W | Per-tile control field sent to the selected tile |
| m_init | input | 1 | Tile number initialisation pulse |
| m_rdata | output | DATA_W | Registered end of the shared AND line |
| m_send | output | N_TILES*DED_W | One-hot per-tile return bits, DED_W per tile number |
| m_aack | output | 1 | Address acknowledge from any tile |
| m_dack | output | 1 | Data acknowledge from any tile |
| t_dout | input | N_TILES*DATA_W | Tile data to the shared line |
| t_drv | input | N_TILES | Tile drive enable |
| t_ioen | input | N_TILES | Tile data I/O enable |
| t_send | input | N_TILES*DED_W | Tile per-tile return bits |
| t_stb | output | N_TILES | Strobe seen by each tile |
| t_we | output | N_TILES | Write flag seen by each tile |
| t_addr | output | N_TILES*ADDR_W | Address seen by each tile |
| t_wdata | output | N_TILES*DATA_W | One-way master data seen by each tile |
| t_rbus | output | N_TILES*DATA_W | Shared line value seen by each tile |
| t_recv | output | N_TILES*DED_W | Per-tile control field seen by each tile |

## Verification
The bench builds the block with four tiles, an 8-bit data line, a 4-bit address and 2-bit per-tile fields. At that size every combination of drive enable and I/O enable across the row (256 cases) can be checked against an AND computed in the bench. Every 8-bit pattern of return bits can be checked against m_send and both acknowledge flags, and every tile number paired with every control value can be checked. The small row also makes it cheap to stream a run of commands one per cycle, to freeze one tile while its neighbours keep moving, and to check all tiles before and after initialisation.

// File: rtl/tbus_pkg.sv
package tbus_pkg;
  // Positions inside each tile's per-tile return group
  localparam int ACK_ADDR_BIT = 0;
  localparam int ACK_DATA_BIT = 1;

  // Width of a binary tile number for a row of n tiles
  function automatic int tid_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tbus_master_port.sv
module tbus_master_port
  import tbus_pkg::*;
#(
  parameter int N      = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 14,
  parameter int DED_W  = 2,
  parameter int TID_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                m_stb,
  input  logic                m_we,
  input  logic [ADDR_W-1:0]   m_addr,
  input  logic [DATA_W-1:0]   m_wdata,
  input  logic [TID_W-1:0]    m_tsel,
  input  logic [DED_W-1:0]    m_ded,
  input  logic                m_init,
  input  logic [DATA_W-1:0]   ret_dat,
  input  logic [N*DED_W-1:0]  ret_snd,
  output logic                d_stb,
  output logic                d_we,
  output logic [ADDR_W-1:0]   d_addr,
  output logic [DATA_W-1:0]   d_wdata,
  output logic [TID_W-1:0]    d_tsel,
  output logic [DED_W-1:0]    d_ded,
  output logic                d_init,
  output logic [DATA_W-1:0]   m_rdata,
  output logic [N*DED_W-1:0]  m_send,
  output logic                m_aack,
  output logic                m_dack
);
  localparam int SND_W = N * DED_W;

  logic [SND_W-1:0] snd_act;
  logic             aack_nxt;
  logic             dack_nxt;

  // Return line is active low on the wires; fold acknowledges per tile group
  always_comb begin
    snd_act  = ~ret_snd;
    aack_nxt = 1'b0;
    dack_nxt = 1'b0;
    for (int i = 0; i < N; i++) begin
      aack_nxt = aack_nxt | snd_act[i*DED_W + ACK_ADDR_BIT];
      dack_nxt = dack_nxt | snd_act[i*DED_W + ACK_DATA_BIT];
    end
  end

  // Command launch registers; payload loads only with a strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_stb   <= 1'b0;
      d_we    <= 1'b0;
      d_addr  <= '0;
      d_wdata <= '0;
      d_tsel  <= '0;
      d_ded   <= '0;
      d_init  <= 1'b0;
    end else begin
      d_stb  <= m_stb;
      d_tsel <= m_tsel;
      d_ded  <= m_ded;
      d_init <= m_init;
      if (m_stb) begin
        d_we    <= m_we;
        d_addr  <= m_addr;
        d_wdata <= m_wdata;
      end
    end
  end

  // Return capture registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdata <= '1;
      m_send  <= '0;
      m_aack  <= 1'b0;
      m_dack  <= 1'b0;
    end else begin
      m_rdata <= ret_dat;
      m_send  <= snd_act;
      m_aack  <= aack_nxt;
      m_dack  <= dack_nxt;
    end
  end
endmodule

// File: rtl/tbus_segment.sv
module tbus_segment #(
  parameter int N      = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 14,
  parameter int DED_W  = 2,
  parameter int TID_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  // common command wires
  input  logic                d_stb,
  input  logic                d_we,
  input  logic [ADDR_W-1:0]   d_addr,
  input  logic [DATA_W-1:0]   d_wdata,
  input  logic [TID_W-1:0]    d_tsel,
  input  logic [DED_W-1:0]    d_ded,
  input  logic                d_init,
  // AND chains and line end
  input  logic [DATA_W-1:0]   dat_i,
  output logic [DATA_W-1:0]   dat_o,
  input  logic [N*DED_W-1:0]  snd_i,
  output logic [N*DED_W-1:0]  snd_o,
  input  logic [DATA_W-1:0]   ret_dat,
  // initialisation position
  input  logic [TID_W-1:0]    pos_i,
  output logic [TID_W-1:0]    id_o,
  output logic                vld_o,
  // tile side
  input  logic [DATA_W-1:0]   t_dout,
  input  logic                t_drv,
  input  logic                t_ioen,
  input  logic [DED_W-1:0]    t_send,
  output logic                t_stb,
  output logic                t_we,
  output logic [ADDR_W-1:0]   t_addr,
  output logic [DATA_W-1:0]   t_wdata,
  output logic [DATA_W-1:0]   t_rbus,
  output logic [DED_W-1:0]    t_recv
);
  localparam int SND_W = N * DED_W;

  logic [DATA_W-1:0] out_q, out_nxt;
  logic [SND_W-1:0]  snd_q, snd_nxt;
  logic [TID_W-1:0]  id_q;
  logic              vld_q;
  logic              stb_q, stb_nxt;
  logic [DED_W-1:0]  recv_q, recv_nxt;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rbus_q;
  logic              id_ld;
  logic              in_en;

  assign id_ld = d_init;
  assign in_en = t_ioen;

  always_comb begin
    // idle tiles present all ones to the AND stage
    out_nxt = (t_drv && t_ioen) ? t_dout : '1;
    // return bits: clear own group only, active low on the wires
    snd_nxt = '1;
    for (int j = 0; j < N; j++) begin
      if (vld_q && (id_q == TID_W'(j))) begin
        snd_nxt[j*DED_W +: DED_W] = ~t_send;
      end
    end
    stb_nxt  = t_ioen & d_stb;
    recv_nxt = (vld_q && (id_q == d_tsel)) ? d_ded : '0;
  end

  // output registers and control capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '1;
      snd_q  <= '1;
      stb_q  <= 1'b0;
      recv_q <= '0;
    end else begin
      out_q  <= out_nxt;
      snd_q  <= snd_nxt;
      stb_q  <= stb_nxt;
      recv_q <= recv_nxt;
    end
  end

  // tile number: written only by the initialisation pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      vld_q <= 1'b0;
    end else if (id_ld) begin
      id_q  <= pos_i;
      vld_q <= 1'b1;
    end
  end

  // data input registers, frozen while the tile's I/O is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rbus_q  <= '0;
    end else if (in_en) begin
      we_q    <= d_we;
      addr_q  <= d_addr;
      wdata_q <= d_wdata;
      rbus_q  <= ret_dat;
    end
  end

  assign dat_o   = dat_i & out_q;
  assign snd_o   = snd_i & snd_q;
  assign id_o    = id_q;
  assign vld_o   = vld_q;
  assign t_stb   = stb_q;
  assign t_we    = we_q;
  assign t_addr  = addr_q;
  assign t_wdata = wdata_q;
  assign t_rbus  = rbus_q;
  assign t_recv  = recv_q;
endmodule

// File: rtl/tbus_chain.sv
module tbus_chain #(
  parameter int N      = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 14,
  parameter int DED_W  = 2,
  parameter int TID_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  d_stb,
  input  logic                  d_we,
  input  logic [ADDR_W-1:0]     d_addr,
  input  logic [DATA_W-1:0]     d_wdata,
  input  logic [TID_W-1:0]      d_tsel,
  input  logic [DED_W-1:0]      d_ded,
  input  logic                  d_init,
  output logic [DATA_W-1:0]     ret_dat,
  output logic [N*DED_W-1:0]    ret_snd,
  output logic [N*TID_W-1:0]    id_vec,
  output logic [N-1:0]          vld_vec,
  input  logic [N*DATA_W-1:0]   t_dout,
  input  logic [N-1:0]          t_drv,
  input  logic [N-1:0]          t_ioen,
  input  logic [N*DED_W-1:0]    t_send,
  output logic [N-1:0]          t_stb,
  output logic [N-1:0]          t_we,
  output logic [N*ADDR_W-1:0]   t_addr,
  output logic [N*DATA_W-1:0]   t_wdata,
  output logic [N*DATA_W-1:0]   t_rbus,
  output logic [N*DED_W-1:0]    t_recv
);
  localparam int SND_W = N * DED_W;

  logic [DATA_W-1:0] dat_lnk [N+1];
  logic [SND_W-1:0]  snd_lnk [N+1];
  logic [TID_W-1:0]  pos_lnk [N];

  assign dat_lnk[0] = '1;
  assign snd_lnk[0] = '1;
  assign pos_lnk[0] = '0;

  for (genvar g = 0; g < N; g++) begin : g_seg
    if (g < N - 1) begin : g_pos
      assign pos_lnk[g+1] = pos_lnk[g] + TID_W'(1);
    end

    tbus_segment #(
      .N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DED_W(DED_W), .TID_W(TID_W)
    ) u_seg (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_stb   (d_stb),
      .d_we    (d_we),
      .d_addr  (d_addr),
      .d_wdata (d_wdata),
      .d_tsel  (d_tsel),
      .d_ded   (d_ded),
      .d_init  (d_init),
      .dat_i   (dat_lnk[g]),
      .dat_o   (dat_lnk[g+1]),
      .snd_i   (snd_lnk[g]),
      .snd_o   (snd_lnk[g+1]),
      .ret_dat (dat_lnk[N]),
      .pos_i   (pos_lnk[g]),
      .id_o    (id_vec[g*TID_W +: TID_W]),
      .vld_o   (vld_vec[g]),
      .t_dout  (t_dout[g*DATA_W +: DATA_W]),
      .t_drv   (t_drv[g]),
      .t_ioen  (t_ioen[g]),
      .t_send  (t_send[g*DED_W +: DED_W]),
      .t_stb   (t_stb[g]),
      .t_we    (t_we[g]),
      .t_addr  (t_addr[g*ADDR_W +: ADDR_W]),
      .t_wdata (t_wdata[g*DATA_W +: DATA_W]),
      .t_rbus  (t_rbus[g*DATA_W +: DATA_W]),
      .t_recv  (t_recv[g*DED_W +: DED_W])
    );
  end

  assign ret_dat = dat_lnk[N];
  assign ret_snd = snd_lnk[N];
endmodule

// File: rtl/tbus_top.sv
module tbus_top
  import tbus_pkg::*;
#(
  parameter  int N_TILES = 8,
  parameter  int DATA_W  = 32,
  parameter  int ADDR_W  = 14,
  parameter  int DED_W   = 2,
  localparam int TID_W   = tid_width(N_TILES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        m_stb,
  input  logic                        m_we,
  input  logic [ADDR_W-1:0]           m_addr,
  input  logic [DATA_W-1:0]           m_wdata,
  input  logic [TID_W-1:0]            m_tsel,
  input  logic [DED_W-1:0]            m_ded,
  input  logic                        m_init,
  output logic [DATA_W-1:0]           m_rdata,
  output logic [N_TILES*DED_W-1:0]    m_send,
  output logic                        m_aack,
  output logic                        m_dack,
  input  logic [N_TILES*DATA_W-1:0]   t_dout,
  input  logic [N_TILES-1:0]          t_drv,
  input  logic [N_TILES-1:0]          t_ioen,
  input  logic [N_TILES*DED_W-1:0]    t_send,
  output logic [N_TILES-1:0]          t_stb,
  output logic [N_TILES-1:0]          t_we,
  output logic [N_TILES*ADDR_W-1:0]   t_addr,
  output logic [N_TILES*DATA_W-1:0]   t_wdata,
  output logic [N_TILES*DATA_W-1:0]   t_rbus,
  output logic [N_TILES*DED_W-1:0]    t_recv
);
  logic                      d_stb;
  logic                      d_we;
  logic [ADDR_W-1:0]         d_addr;
  logic [DATA_W-1:0]         d_wdata;
  logic [TID_W-1:0]          d_tsel;
  logic [DED_W-1:0]          d_ded;
  logic                      d_init;
  logic [DATA_W-1:0]         ret_dat;
  logic [N_TILES*DED_W-1:0]  ret_snd;
  logic [N_TILES*TID_W-1:0]  tid_vec;
  logic [N_TILES-1:0]        tid_vld;

  tbus_master_port #(
    .N(N_TILES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DED_W(DED_W), .TID_W(TID_W)
  ) u_mport (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_stb   (m_stb),
    .m_we    (m_we),
    .m_addr  (m_addr),
    .m_wdata (m_wdata),
    .m_tsel  (m_tsel),
    .m_ded   (m_ded),
    .m_init  (m_init),
    .ret_dat (ret_dat),
    .ret_snd (ret_snd),
    .d_stb   (d_stb),
    .d_we    (d_we),
    .d_addr  (d_addr),
    .d_wdata (d_wdata),
    .d_tsel  (d_tsel),
    .d_ded   (d_ded),
    .d_init  (d_init),
    .m_rdata (m_rdata),
    .m_send  (m_send),
    .m_aack  (m_aack),
    .m_dack  (m_dack)
  );

  tbus_chain #(
    .N(N_TILES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DED_W(DED_W), .TID_W(TID_W)
  ) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_stb   (d_stb),
    .d_we    (d_we),
    .d_addr  (d_addr),
    .d_wdata (d_wdata),
    .d_tsel  (d_tsel),
    .d_ded   (d_ded),
    .d_init  (d_init),
    .ret_dat (ret_dat),
    .ret_snd (ret_snd),
    .id_vec  (tid_vec),
    .vld_vec (tid_vld),
    .t_dout  (t_dout),
    .t_drv   (t_drv),
    .t_ioen  (t_ioen),
    .t_send  (t_send),
    .t_stb   (t_stb),
    .t_we    (t_we),
    .t_addr  (t_addr),
    .t_wdata (t_wdata),
    .t_rbus  (t_rbus),
    .t_recv  (t_recv)
  );
endmodule

// File: rtl/tbus_chk.sv
module tbus_chk #(
  parameter int N      = 8,
  parameter int DATA_W = 32,
  parameter int DED_W  = 2,
  parameter int TID_W  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                m_stb,
  input logic                m_init,
  input logic [DATA_W-1:0]   m_rdata,
  input logic [N*DED_W-1:0]  m_send,
  input logic                m_aack,
  input logic                m_dack,
  input logic [N-1:0]        t_drv,
  input logic [N-1:0]        t_ioen,
  input logic [N*DED_W-1:0]  t_send,
  input logic [N-1:0]        t_stb,
  input logic [N*DED_W-1:0]  t_recv,
  input logic [N*TID_W-1:0]  tid_vec,
  input logic [N-1:0]        tid_vld
);
  logic [1:0]   cyc;
  logic [N-1:0] rx_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  always_comb begin
    for (int i = 0; i < N; i++) rx_any[i] = |t_recv[i*DED_W +: DED_W];
  end

  // R3: line idles at all ones when no tile drove two edges back
  p_rdata_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc >= 2'd2) && $past((t_drv & t_ioen) == '0, 2)) |-> (m_rdata == '1));

  // R8 / R9: no return bits and no acknowledges without tile requests
  p_send_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc >= 2'd2) && $past(t_send == '0, 2)) |-> ((m_send == '0) && !m_aack && !m_dack));

  // R7: at most one tile receives a control field at a time
  p_recv_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_any));

  // R6: tile numbers move only two edges after an init pulse
  p_id_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc >= 2'd2) && !$past(m_init, 2)) |-> ($stable(tid_vec) && $stable(tid_vld)));

  for (genvar g = 0; g < N; g++) begin : g_tile
    // R2: strobe reaches an enabled tile with fixed latency
    p_stb_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2) |-> (t_stb[g] == ($past(m_stb, 2) && $past(t_ioen[g]))));
    // R7: an un-numbered tile never receives
    p_recv_noid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tid_vld[g] |-> !rx_any[g]);
  end
endmodule

bind tbus_top tbus_chk #(
  .N(N_TILES), .DATA_W(DATA_W), .DED_W(DED_W), .TID_W(TID_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .m_stb   (m_stb),
  .m_init  (m_init),
  .m_rdata (m_rdata),
  .m_send  (m_send),
  .m_aack  (m_aack),
  .m_dack  (m_dack),
  .t_drv   (t_drv),
  .t_ioen  (t_ioen),
  .t_send  (t_send),
  .t_stb   (t_stb),
  .t_recv  (t_recv),
  .tid_vec (tid_vec),
  .tid_vld (tid_vld)
);

// File: tb/sim_tbus_top.sv
module sim_tbus_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int DW  = 8;
  localparam int AW  = 4;
  localparam int DED = 2;
  localparam int TW  = 2;

  logic            clk;
  logic            rst_n;
  logic            m_stb, m_we, m_init;
  logic [AW-1:0]   m_addr;
  logic [DW-1:0]   m_wdata;
  logic [TW-1:0]   m_tsel;
  logic [DED-1:0]  m_ded;
  logic [DW-1:0]   m_rdata;
  logic [N*DED-1:0] m_send;
  logic            m_aack, m_dack;
  logic [N*DW-1:0] t_dout;
  logic [N-1:0]    t_drv, t_ioen;
  logic [N*DED-1:0] t_send;
  logic [N-1:0]    t_stb, t_we;
  logic [N*AW-1:0] t_addr;
  logic [N*DW-1:0] t_wdata, t_rbus;
  logic [N*DED-1:0] t_recv;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  tbus_top #(.N_TILES(N), .DATA_W(DW), .ADDR_W(AW), .DED_W(DED)) u0 (
    .clk(clk), .rst_n(rst_n),
    .m_stb(m_stb), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_tsel(m_tsel), .m_ded(m_ded), .m_init(m_init),
    .m_rdata(m_rdata), .m_send(m_send), .m_aack(m_aack), .m_dack(m_dack),
    .t_dout(t_dout), .t_drv(t_drv), .t_ioen(t_ioen), .t_send(t_send),
    .t_stb(t_stb), .t_we(t_we), .t_addr(t_addr), .t_wdata(t_wdata),
    .t_rbus(t_rbus), .t_recv(t_recv)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] exp_and;
    logic          p_stb, p_we;
    logic [AW-1:0] p_addr, l_addr;
    logic [DW-1:0] p_wdata, l_wdata;
    logic          l_we;

    rst_n = 1'b0;
    m_stb = 0; m_we = 0; m_init = 0; m_addr = '0; m_wdata = '0;
    m_tsel = '0; m_ded = '0;
    t_dout = '0; t_drv = '0; t_ioen = '0; t_send = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    chk("R1 m_rdata", 64'(m_rdata), 64'hFF);
    chk("R1 m_send", 64'(m_send), 64'h0);
    chk("R1 m_aack/m_dack", 64'({m_aack, m_dack}), 64'h0);
    chk("R1 t_stb/t_we", 64'({t_stb, t_we}), 64'h0);
    chk("R1 t_wdata", 64'(t_wdata), 64'h0);
    chk("R1 t_rbus", 64'(t_rbus), 64'h0);
    chk("R1 t_recv", 64'(t_recv), 64'h0);

    // R7/R8: nothing selected before initialisation
    t_ioen = '1;
    m_tsel = 2'd0; m_ded = 2'd3; t_send = '1;
    tick(); tick();
    chk("R7 t_recv before init", 64'(t_recv), 64'h0);
    chk("R8 m_send before init", 64'(m_send), 64'h0);
    chk("R9 acks before init", 64'({m_aack, m_dack}), 64'h0);
    t_send = '0;

    // R6: one init pulse numbers the row
    m_init = 1'b1;
    tick();
    m_init = 1'b0;
    tick(); tick();

    // R6/R7: every tile number with every control value
    for (int s = 0; s < N; s++) begin
      for (int v = 0; v < 4; v++) begin
        m_tsel = TW'(s); m_ded = DED'(v);
        tick(); tick();
        for (int i = 0; i < N; i++)
          chk($sformatf("R7 R6 t_recv tile%0d sel%0d", i, s),
              64'(t_recv[i*DED +: DED]), (i == s) ? 64'(v) : 64'h0);
      end
    end
    m_ded = '0;

    // R8/R9: every return pattern
    for (int v = 0; v < 256; v++) begin
      t_send = 8'(v);
      tick(); tick();
      chk("R8 m_send", 64'(m_send), 64'(v));
      chk("R9 m_aack", 64'(m_aack), 64'(v[0] | v[2] | v[4] | v[6]));
      chk("R9 m_dack", 64'(m_dack), 64'(v[1] | v[3] | v[5] | v[7]));
    end
    t_send = '0;

    // R3/R4: every drive and I/O enable combination
    for (int dm = 0; dm < 16; dm++) begin
      for (int im = 0; im < 16; im++) begin
        t_drv = 4'(dm); t_ioen = 4'(im);
        exp_and = '1;
        for (int i = 0; i < N; i++) begin
          t_dout[i*DW +: DW] = ~(DW'(8'h01 << i) | DW'(8'h10 << ((dm + im + i) % 4)));
          if (dm[i] && im[i]) exp_and = exp_and & t_dout[i*DW +: DW];
        end
        tick(); tick();
        chk("R3 m_rdata", 64'(m_rdata), 64'(exp_and));
        for (int i = 0; i < N; i++)
          if (im[i]) chk($sformatf("R4 t_rbus tile%0d", i), 64'(t_rbus[i*DW +: DW]), 64'(exp_and));
      end
    end
    t_drv = '0;

    // R2/R10: one command per cycle
    t_ioen = '1;
    p_stb = 0; p_we = 0; p_addr = '0; p_wdata = '0;
    l_we = u0_last_we(); l_addr = '0; l_wdata = '0;
    // establish a known last command first
    m_stb = 1; m_we = 0; m_addr = 4'h0; m_wdata = 8'h00;
    tick(); tick();
    l_we = 0; l_addr = '0; l_wdata = '0;
    for (int k = 0; k < 24; k++) begin
      m_stb = (k % 3) != 2; m_we = k[0]; m_addr = AW'(k * 5); m_wdata = DW'(k * 37 + 1);
      tick();
      if (k >= 1) begin
        if (p_stb) begin l_we = p_we; l_addr = p_addr; l_wdata = p_wdata; end
        chk("R2 t_stb all tiles", 64'(t_stb), p_stb ? 64'hF : 64'h0);
        for (int i = 0; i < N; i++) begin
          chk("R10 t_wdata", 64'(t_wdata[i*DW +: DW]), 64'(l_wdata));
          chk("R10 t_addr", 64'(t_addr[i*AW +: AW]), 64'(l_addr));
          chk("R10 t_we", 64'(t_we[i]), 64'(l_we));
        end
      end
      p_stb = m_stb; p_we = m_we; p_addr = m_addr; p_wdata = m_wdata;
    end

    // R5: a tile with I/O off is ignored and frozen
    m_stb = 1; m_wdata = 8'hC3; t_ioen = '1; t_drv = 4'b0001;
    t_dout = '1; t_dout[0 +: DW] = 8'h5A;
    tick(); tick();
    t_ioen = 4'b1101; t_drv = 4'b0010; t_dout = '1; t_dout[DW +: DW] = 8'h00;
    m_wdata = 8'h3C;
    tick(); tick();
    chk("R5 m_rdata ignores off tile", 64'(m_rdata), 64'hFF);
    chk("R5 off tile t_wdata held", 64'(t_wdata[DW +: DW]), 64'hC3);
    chk("R5 off tile t_rbus held", 64'(t_rbus[DW +: DW]), 64'h5A);
    chk("R5 R2 off tile t_stb", 64'(t_stb[1]), 64'h0);
    chk("R5 on tile t_wdata", 64'(t_wdata[0 +: DW]), 64'h3C);
    chk("R5 on tile t_rbus", 64'(t_rbus[0 +: DW]), 64'hFF);
    m_stb = 0; t_drv = '0; t_ioen = '1;

    // R6: tile numbers kept long after initialisation
    m_tsel = 2'd2; m_ded = 2'd1;
    tick(); tick();
    chk("R6 numbers held", 64'(t_recv), 64'h10);

    finish_run();
  end

  function automatic logic u0_last_we();
    return 1'b0;
  endfunction
endmodule